// File: doc/BRIEF.md
# Two-Stage Sticky Interrupt Aggregator

This block collects the interrupt sources of a low-pin-count bus host controller into a single interrupt line. The sources are up to seventeen already-decoded serial interrupt lines and nine bus event strobes. The first stage latches every source into a sticky status register. Software clears that register by writing ones to it. A mask and a global enable reduce the stage to one forwarded bit.

The second stage samples the forwarded bit into a read-only input register. It then latches the masked input into its own sticky status register, which software also clears by writing ones. The interrupt output is high whenever that status is non-zero. The second stage also keeps a polarity register and two routing registers. Software can read and write these, but they have no effect on the interrupt logic.

Each stage has its own 32-bit word register port with a write strobe and a combinational read. Register reads have no side effects. All state is re-evaluated on every clock.

Top module: `irq_agg_top`

## Requirements
- R1: A high level on serial line n (0..16) sets first-stage status bit 31−n at the next clock edge. The bit stays set after the line returns low.
- R2: Each event input sets one first-stage status bit. Inputs 0..7 set status bits 0..7, and input 8 (bus reset) sets status bit 10. Status bits 8, 9 and 11..14 never set.
- R3: A write to first-stage status (offset 0x38) clears exactly the bits that are 1 in the written word. If a source is setting a bit in the same cycle, the set wins.
- R4: The first-stage result is control bit 31 (offset 0x30) ANDed with "status AND mask (offset 0x34) is non-zero". This result appears as bit 11 of the second-stage input register (offset 0x5C) one clock later. All other input bits read 0.
- R5: On every clock, second-stage status (offset 0x50) ORs in "input AND mask (offset 0x54)". A write to offset 0x50 clears the bits that are 1 in the written word, except that a bit being set in the same cycle stays set. Bits stay set until cleared.
- R6: `irq_o` is high exactly when second-stage status is non-zero.
- R7: The following are plain read/write registers that return the last word written: segment select 0x24, read access size 0x28, control 0x30, first mask 0x34, route 0x08 and 0x0C, second mask 0x54, and polarity 0x58. Polarity and the route registers do not change `irq_o`.
- R8: After reset, read access size reads 0x02000000 and every other register reads 0. `irq_o` is low after reset.
- R9: A read of any offset not listed above returns 0xFFFFFFFF. Writes to unlisted offsets, to error address 0x40 (which reads 0) and to the input register 0x5C change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serirq_i | input | 17 | Decoded serial interrupt levels, line n at bit n |
| ev_i | input | 9 | Bus event strobes, mapped as in R2 |
| hc_we | input | 1 | First-stage register write strobe |
| hc_addr | input | 8 | First-stage register byte offset |
| hc_wdata | input | 32 | First-stage write data |
| hc_rdata | output | 32 | First-stage read data (combinational) |
| om_we | input | 1 | Second-stage register write strobe |
| om_addr | input | 8 | Second-stage register byte offset |
| om_wdata | input | 32 | Second-stage write data |
| om_rdata | output | 32 | Second-stage read data (combinational) |
| irq_o | output | 1 | Aggregated interrupt output |

## Verification
The bench builds the block with its default of seventeen serial lines and nine events. This puts every source bit within reach of a one-by-one sweep, which confirms the bit each source maps to and that each set is sticky.

Both 8-bit offset spaces are swept over every word offset, together with some unaligned offsets. Each unlisted offset must read all ones, and writes to it must leave the listed registers intact.

The cascade is driven through each combination of enable and both masks. The bench also checks the two-cycle source-to-output latency, and the case where a set and a clear land in the same cycle.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int DW        = 32;
  localparam int AW        = 8;
  localparam int MAX_LINES = 17;
  localparam int NUM_EV    = 9;
  localparam int EN_BIT    = 31;
  localparam int FWD_BIT   = 11;
  localparam int BUSRST_BIT = 10;

  localparam logic [AW-1:0] OFF_SEG    = 8'h24;
  localparam logic [AW-1:0] OFF_ACC    = 8'h28;
  localparam logic [AW-1:0] OFF_CTRL   = 8'h30;
  localparam logic [AW-1:0] OFF_MASK1  = 8'h34;
  localparam logic [AW-1:0] OFF_STAT1  = 8'h38;
  localparam logic [AW-1:0] OFF_ERRA   = 8'h40;

  localparam logic [AW-1:0] OFF_ROUTEA = 8'h08;
  localparam logic [AW-1:0] OFF_ROUTEB = 8'h0C;
  localparam logic [AW-1:0] OFF_STAT2  = 8'h50;
  localparam logic [AW-1:0] OFF_MASK2  = 8'h54;
  localparam logic [AW-1:0] OFF_POL    = 8'h58;
  localparam logic [AW-1:0] OFF_INPUT  = 8'h5C;

  localparam logic [DW-1:0] ACC_RESET  = 32'h0200_0000;
  localparam logic [DW-1:0] ALL_ONES   = '1;

  // line n lands on bit (DW-1-n)
  function automatic logic [DW-1:0] line_bits(input logic [MAX_LINES-1:0] lines);
    logic [DW-1:0] v;
    v = '0;
    for (int n = 0; n < MAX_LINES; n++) v[DW-1-n] = lines[n];
    return v;
  endfunction

  // events 0..7 land on bits 0..7, event 8 on the bus-reset bit
  function automatic logic [DW-1:0] event_bits(input logic [NUM_EV-1:0] ev);
    logic [DW-1:0] v;
    v = '0;
    v[7:0] = ev[7:0];
    v[BUSRST_BIT] = ev[8];
    return v;
  endfunction

  // one-clock sticky update: clear first, set wins
  function automatic logic [DW-1:0] sticky_next(input logic [DW-1:0] cur,
                                                input logic [DW-1:0] set,
                                                input logic [DW-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/sticky_w1c.sv
module sticky_w1c
  import irqagg_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= W'(sticky_next(DW'(q), DW'(set_i), DW'(clr_i)));
  end

  assign q_o = q;

  // a set request is visible on the next cycle regardless of clears
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i))); // R3
endmodule

// File: rtl/hc_irq_stage.sv
module hc_irq_stage
  import irqagg_pkg::*;
#(
  parameter int N_LINES = MAX_LINES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_i,
  input  logic [NUM_EV-1:0]  ev_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               en_o,
  output logic               fwd_o
);
  logic [DW-1:0] seg_q, acc_q, ctrl_q, mask_q, stat_q;
  logic [DW-1:0] set_vec, clr_vec, line_vec, hit_vec;
  logic [MAX_LINES-1:0] lines_ext;

  always_comb begin
    lines_ext = '0;
    lines_ext[N_LINES-1:0] = lines_i;
  end

  assign line_vec = line_bits(lines_ext);
  assign set_vec  = line_vec | event_bits(ev_i);
  assign clr_vec  = (we_i && addr_i == OFF_STAT1) ? wdata_i : '0;

  sticky_w1c #(.W(DW)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .q_o   (stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= '0;
      acc_q  <= ACC_RESET;
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFF_SEG:   seg_q  <= wdata_i;
        OFF_ACC:   acc_q  <= wdata_i;
        OFF_CTRL:  ctrl_q <= wdata_i;
        OFF_MASK1: mask_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      OFF_SEG:   rdata_o = seg_q;
      OFF_ACC:   rdata_o = acc_q;
      OFF_CTRL:  rdata_o = ctrl_q;
      OFF_MASK1: rdata_o = mask_q;
      OFF_STAT1: rdata_o = stat_q;
      OFF_ERRA:  rdata_o = '0;
      default:   rdata_o = ALL_ONES;
    endcase
  end

  assign hit_vec = stat_q & mask_q;
  assign en_o    = ctrl_q[EN_BIT];
  assign fwd_o   = en_o & (|hit_vec);

  AST_LINE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|lines_i) |=> ((stat_q & $past(line_vec)) == $past(line_vec))); // R1
  AST_S1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R3
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[14:11] == 4'b0) && (stat_q[9:8] == 2'b0)); // R2
endmodule

// File: rtl/opb_irq_stage.sv
module opb_irq_stage
  import irqagg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] in_o,
  output logic          irq_o
);
  logic [DW-1:0] routea_q, routeb_q, mask_q, pol_q, in_q, stat_q;
  logic [DW-1:0] in_d, set_vec, clr_vec;

  always_comb begin
    in_d = '0;
    in_d[FWD_BIT] = fwd_i;
  end

  assign set_vec = in_q & mask_q;
  assign clr_vec = (we_i && addr_i == OFF_STAT2) ? wdata_i : '0;

  sticky_w1c #(.W(DW)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .q_o   (stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= in_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      routea_q <= '0;
      routeb_q <= '0;
      mask_q   <= '0;
      pol_q    <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFF_ROUTEA: routea_q <= wdata_i;
        OFF_ROUTEB: routeb_q <= wdata_i;
        OFF_MASK2:  mask_q   <= wdata_i;
        OFF_POL:    pol_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      OFF_ROUTEA: rdata_o = routea_q;
      OFF_ROUTEB: rdata_o = routeb_q;
      OFF_STAT2:  rdata_o = stat_q;
      OFF_MASK2:  rdata_o = mask_q;
      OFF_POL:    rdata_o = pol_q;
      OFF_INPUT:  rdata_o = in_q;
      default:    rdata_o = ALL_ONES;
    endcase
  end

  assign in_o  = in_q;
  assign irq_o = |stat_q;

  AST_S2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R5
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (($past(in_q) & $past(mask_q)) != '0)); // R6
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irqagg_pkg::*;
#(
  parameter int N_LINES = MAX_LINES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] serirq_i,
  input  logic [NUM_EV-1:0]  ev_i,
  input  logic               hc_we,
  input  logic [AW-1:0]      hc_addr,
  input  logic [DW-1:0]      hc_wdata,
  output logic [DW-1:0]      hc_rdata,
  input  logic               om_we,
  input  logic [AW-1:0]      om_addr,
  input  logic [DW-1:0]      om_wdata,
  output logic [DW-1:0]      om_rdata,
  output logic               irq_o
);
  logic          s1_en;
  logic          s1_fwd;
  logic [DW-1:0] s2_in;

  hc_irq_stage #(.N_LINES(N_LINES)) u_hc (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_i (serirq_i),
    .ev_i    (ev_i),
    .we_i    (hc_we),
    .addr_i  (hc_addr),
    .wdata_i (hc_wdata),
    .rdata_o (hc_rdata),
    .en_o    (s1_en),
    .fwd_o   (s1_fwd)
  );

  opb_irq_stage u_om (
    .clk     (clk),
    .rst_n   (rst_n),
    .fwd_i   (s1_fwd),
    .we_i    (om_we),
    .addr_i  (om_addr),
    .wdata_i (om_wdata),
    .rdata_o (om_rdata),
    .in_o    (s2_in),
    .irq_o   (irq_o)
  );

  AST_FWD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    s2_in[FWD_BIT] |-> $past(s1_en)); // R4
  AST_IN_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(s2_in) <= 1); // R4
endmodule

// File: tb/sim_irq_agg_top.sv
`timescale 1ns/1ps
module sim_irq_agg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] serirq = '0;
  logic [8:0]  ev = '0;
  logic        hc_we = 1'b0, om_we = 1'b0;
  logic [7:0]  hc_addr = '0, om_addr = '0;
  logic [31:0] hc_wdata = '0, om_wdata = '0;
  logic [31:0] hc_rdata, om_rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  irq_agg_top u0 (
    .clk(clk), .rst_n(rst_n), .serirq_i(serirq), .ev_i(ev),
    .hc_we(hc_we), .hc_addr(hc_addr), .hc_wdata(hc_wdata), .hc_rdata(hc_rdata),
    .om_we(om_we), .om_addr(om_addr), .om_wdata(om_wdata), .om_rdata(om_rdata),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic hc_wr(input logic [7:0] a, input logic [31:0] d);
    hc_addr = a; hc_wdata = d; hc_we = 1'b1;
    @(negedge clk);
    hc_we = 1'b0;
  endtask

  task automatic om_wr(input logic [7:0] a, input logic [31:0] d);
    om_addr = a; om_wdata = d; om_we = 1'b1;
    @(negedge clk);
    om_we = 1'b0;
  endtask

  task automatic hc_rd(input logic [7:0] a, output logic [31:0] d);
    hc_addr = a; #0.5; d = hc_rdata;
  endtask

  task automatic om_rd(input logic [7:0] a, output logic [31:0] d);
    om_addr = a; #0.5; d = om_rdata;
  endtask

  function automatic bit hc_known(input logic [7:0] a);
    return a == 8'h24 || a == 8'h28 || a == 8'h30 || a == 8'h34 ||
           a == 8'h38 || a == 8'h40;
  endfunction

  function automatic bit om_known(input logic [7:0] a);
    return a == 8'h08 || a == 8'h0C || a == 8'h50 || a == 8'h54 ||
           a == 8'h58 || a == 8'h5C;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R8 reset values
    hc_rd(8'h24, d); chk("R8 seg", d, 32'h0);
    hc_rd(8'h28, d); chk("R8 acc", d, 32'h0200_0000);
    hc_rd(8'h30, d); chk("R8 ctrl", d, 32'h0);
    hc_rd(8'h34, d); chk("R8 mask1", d, 32'h0);
    hc_rd(8'h38, d); chk("R8 stat1", d, 32'h0);
    hc_rd(8'h40, d); chk("R8 erraddr", d, 32'h0);
    for (int a = 0; a < 6; a++) begin
      logic [7:0] offs [6];
      offs = '{8'h08, 8'h0C, 8'h50, 8'h54, 8'h58, 8'h5C};
      om_rd(offs[a], d); chk("R8 stage2 reg", d, 32'h0);
    end
    chk("R8 irq", {31'b0, irq}, 32'h0);

    // R1 serial lines sweep: latch at bit 31-n, sticky after release
    for (int n = 0; n < 17; n++) begin
      serirq = 17'(1) << n;
      step(1);
      serirq = '0;
      step(2);
      hc_rd(8'h38, d); chk("R1 line latch", d, 32'h8000_0000 >> n);
      hc_wr(8'h38, 32'hFFFF_FFFF);
      hc_rd(8'h38, d); chk("R3 clear all", d, 32'h0);
    end

    // R2 event sweep
    for (int i = 0; i < 9; i++) begin
      ev = 9'(1) << i;
      step(1);
      ev = '0;
      hc_rd(8'h38, d);
      chk("R2 event bit", d, (i == 8) ? 32'h0000_0400 : (32'h1 << i));
      hc_wr(8'h38, 32'hFFFF_FFFF);
    end

    // R3 partial clear and set-wins
    serirq = 17'h00003; step(1); serirq = '0;
    hc_wr(8'h38, 32'h8000_0000);
    hc_rd(8'h38, d); chk("R3 partial clear", d, 32'h4000_0000);
    serirq = 17'h00008;
    hc_wr(8'h38, 32'hFFFF_FFFF);
    hc_rd(8'h38, d); chk("R3 set wins over clear", d, 32'h1000_0000);
    serirq = '0;
    hc_wr(8'h38, 32'hFFFF_FFFF);
    hc_rd(8'h38, d); chk("R3 cleared", d, 32'h0);

    // R7 read/write registers
    hc_wr(8'h24, 32'hA5A5_0001); hc_rd(8'h24, d); chk("R7 seg", d, 32'hA5A5_0001);
    hc_wr(8'h28, 32'h0700_0000); hc_rd(8'h28, d); chk("R7 acc", d, 32'h0700_0000);
    hc_wr(8'h30, 32'h4300_0000); hc_rd(8'h30, d); chk("R7 ctrl", d, 32'h4300_0000);
    hc_wr(8'h34, 32'h0000_FFFF); hc_rd(8'h34, d); chk("R7 mask1", d, 32'h0000_FFFF);
    om_wr(8'h08, 32'h1234_5678); om_rd(8'h08, d); chk("R7 routeA", d, 32'h1234_5678);
    om_wr(8'h0C, 32'h8765_4321); om_rd(8'h0C, d); chk("R7 routeB", d, 32'h8765_4321);
    om_wr(8'h58, 32'h0000_0800); om_rd(8'h58, d); chk("R7 pol", d, 32'h0000_0800);
    om_wr(8'h54, 32'hFFFF_0000); om_rd(8'h54, d); chk("R7 mask2", d, 32'hFFFF_0000);

    // R9 error address and input writes ignored
    hc_wr(8'h40, 32'hDEAD_BEEF); hc_rd(8'h40, d); chk("R9 erraddr write", d, 32'h0);
    om_wr(8'h5C, 32'hFFFF_FFFF); om_rd(8'h5C, d); chk("R9 input write", d, 32'h0);
    om_rd(8'h50, d); chk("R9 input write no latch", d, 32'h0);

    // R9 unimplemented offsets: reads all ones, writes harmless
    for (int a = 0; a < 256; a += 4) begin
      if (!hc_known(8'(a))) begin
        hc_wr(8'(a), 32'h0);
        hc_rd(8'(a), d); chk("R9 hc unimpl read", d, 32'hFFFF_FFFF);
      end
      if (!om_known(8'(a))) begin
        om_wr(8'(a), 32'h0);
        om_rd(8'(a), d); chk("R9 om unimpl read", d, 32'hFFFF_FFFF);
      end
    end
    hc_rd(8'h25, d); chk("R9 hc unaligned", d, 32'hFFFF_FFFF);
    om_rd(8'h51, d); chk("R9 om unaligned", d, 32'hFFFF_FFFF);
    hc_rd(8'h24, d); chk("R9 seg kept", d, 32'hA5A5_0001);
    hc_rd(8'h28, d); chk("R9 acc kept", d, 32'h0700_0000);
    hc_rd(8'h30, d); chk("R9 ctrl kept", d, 32'h4300_0000);
    hc_rd(8'h34, d); chk("R9 mask1 kept", d, 32'h0000_FFFF);
    om_rd(8'h08, d); chk("R9 routeA kept", d, 32'h1234_5678);
    om_rd(8'h0C, d); chk("R9 routeB kept", d, 32'h8765_4321);
    om_rd(8'h54, d); chk("R9 mask2 kept", d, 32'hFFFF_0000);
    om_rd(8'h58, d); chk("R9 pol kept", d, 32'h0000_0800);

    // R4/R5/R6 cascade over enable x mask1 x mask2
    for (int c = 0; c < 8; c++) begin
      bit en, m1, m2;
      logic [31:0] exp_in;
      en = c[0]; m1 = c[1]; m2 = c[2];
      hc_wr(8'h30, 32'h0);
      hc_wr(8'h34, m1 ? 32'h0000_4000 : 32'h0000_0010); // line 17-? bit 14 unused
      hc_wr(8'h34, m1 ? 32'h8000_0000 : 32'h4000_0000);
      om_wr(8'h54, m2 ? 32'h0000_0800 : 32'hFFFF_F7FF);
      om_wr(8'h58, 32'hFFFF_FFFF);
      serirq = 17'h00001; step(1); serirq = '0;
      hc_wr(8'h30, en ? 32'h8000_0000 : 32'h0);
      // forwarded bit appears one clock after the enable write
      exp_in = (en && m1) ? 32'h0000_0800 : 32'h0;
      om_rd(8'h5C, d); chk("R4 fwd not yet", d, 32'h0);
      step(1);
      om_rd(8'h5C, d); chk("R4 fwd input", d, exp_in);
      chk("R6 irq lag", {31'b0, irq}, 32'h0);
      step(1);
      om_rd(8'h50, d); chk("R5 stat2 latch", d, (en && m1 && m2) ? 32'h0000_0800 : 32'h0);
      chk("R6 irq", {31'b0, irq}, {31'b0, en && m1 && m2});
      // clear stage 1; stage 2 stays sticky
      hc_wr(8'h38, 32'hFFFF_FFFF);
      step(3);
      om_rd(8'h5C, d); chk("R4 fwd dropped", d, 32'h0);
      chk("R5 irq sticky", {31'b0, irq}, {31'b0, en && m1 && m2});
      om_wr(8'h58, 32'h0); // polarity has no effect
      chk("R7 pol no effect", {31'b0, irq}, {31'b0, en && m1 && m2});
      om_wr(8'h50, 32'hFFFF_FFFF);
      om_rd(8'h50, d); chk("R5 stat2 cleared", d, 32'h0);
      chk("R6 irq low", {31'b0, irq}, 32'h0);
    end

    // R5 set wins over clear in stage 2 while source remains active
    hc_wr(8'h34, 32'h0000_0400);
    om_wr(8'h54, 32'h0000_0800);
    ev = 9'h100; step(1); ev = '0;
    step(2);
    om_wr(8'h50, 32'h0000_0800);
    om_rd(8'h50, d); chk("R5 relatch while input high", d, 32'h0000_0800);
    hc_wr(8'h38, 32'h0000_0400);
    step(3);
    om_wr(8'h50, 32'h0000_0800);
    om_rd(8'h50, d); chk("R5 clears once input low", d, 32'h0);
    chk("R6 final irq low", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule